// File: doc/BRIEF.md
# Translation Buffer with Base-Bounded Victim Replacement

This block is a small fully associative translation buffer that maps virtual page numbers to physical page numbers. A lookup port compares the incoming virtual page against every valid entry in the same cycle. It returns the physical page on a hit. On a miss it raises a walk request. Results from an external table walker come back through a fill port and are written into the table.

Replacement is steered by a software-visible control register with three fields:
- a floor index: entries below it are never picked by the automatic pointer;
- a victim index: the entry the next new translation goes into;
- a keep bit: it is copied into the preserve flag of each entry written by a fill.

To pin translations into the low entries, software sets floor, victim and keep for each slot in turn and forces one walk per slot. It then raises the floor above the pinned group and clears keep. A flush pulse removes every entry that does not carry the preserve flag.

Top module: `tlb_lockdown_top`

## Requirements
- R1: After reset every lookup misses, and the control read port returns floor 0, victim 0 and keep 0.
- R2: A lookup with `lk_valid` high hits in the same cycle when exactly one valid entry holds the virtual page, and `lk_ppn` then carries that entry's physical page. A lookup that misses raises `walk_req` in the same cycle.
- R3: A fill whose virtual page matches no valid entry writes the entry at the current victim index. That entry becomes valid and takes the current keep bit as its preserve flag.
- R4: After a fill into the victim entry, the victim index goes up by one. When the victim index is the last entry (ENTRIES-1), it goes to the floor index instead.
- R5: A victim index that software writes below the floor is used as-is for the next fill. It then goes up by one per fill under the R4 rule.
- R6: A fill whose virtual page matches a valid entry overwrites that entry's physical page and preserve flag, and the victim index does not change.
- R7: A flush pulse clears every entry whose preserve flag is 0 and leaves entries with preserve flag 1 valid and unchanged.
- R8: A control write loads floor, victim and keep at the next edge, and the read port shows them. When a control write and a fill land in the same cycle, the fill uses the old victim and keep, and the written values win with no auto-advance.
- R9: With floor N, any number of fills into the victim entry leaves entries 0 to N-1 untouched.
- R10: A fill in the same cycle as a flush leaves the filled entry valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_ppn | output | PPN_W | Physical page on a hit, 0 otherwise |
| walk_req | output | 1 | Lookup missed, walk needed |
| fill_en | input | 1 | Fill strobe from the walker |
| fill_vpn | input | VPN_W | Virtual page to install |
| fill_ppn | input | PPN_W | Physical page to install |
| flush | input | 1 | Invalidate all non-preserved entries |
| cr_wr_en | input | 1 | Control register write strobe |
| cr_wr_floor | input | IDX_W | Floor index to write |
| cr_wr_victim | input | IDX_W | Victim index to write |
| cr_wr_keep | input | 1 | Keep bit to write |
| cr_rd_floor | output | IDX_W | Current floor index |
| cr_rd_victim | output | IDX_W | Current victim index |
| cr_rd_keep | output | 1 | Current keep bit |

## Verification
Different internal faults show up at different times:
- A wrong victim pointer shows on the read port one edge after the fill that moved it.
- A translation written into the wrong slot only shows later, as an eviction: a lookup misses on a page that should have stayed, or a pinned page vanishes after the table wraps.
- A lost or wrongly set preserve flag shows on the first lookup after a flush.

The bench therefore fills the table past its capacity and checks which pages survive. It also drives fills together with control writes and flushes, and fills to a page already present.

// File: rtl/tlbl_pkg.sv
// Shared defaults for the translation buffer with base-bounded replacement.
// Assumes nothing beyond plain parameter use by the modules below.
package tlbl_pkg;
    localparam int DEF_ENTRIES = 8;
    localparam int DEF_VPN_W   = 20;
    localparam int DEF_PPN_W   = 20;
endpackage

// File: rtl/tlbl_ctrl.sv
// Control register: floor index, victim index, keep bit.
// Advances the victim pointer after each fill into the victim slot,
// wrapping from the last entry back to the floor. Software writes win
// over an advance in the same cycle. Assumes written indices < ENTRIES.
module tlbl_ctrl #(
    parameter int ENTRIES = tlbl_pkg::DEF_ENTRIES,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_floor,
    input  logic [IDX_W-1:0] wr_victim,
    input  logic             wr_keep,
    input  logic             advance,
    output logic [IDX_W-1:0] floor_q,
    output logic [IDX_W-1:0] victim_q,
    output logic             keep_q
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Register update: reset, software load, or pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            floor_q  <= '0;
            victim_q <= '0;
            keep_q   <= 1'b0;
        end else if (wr_en) begin
            floor_q  <= wr_floor;
            victim_q <= wr_victim;
            keep_q   <= wr_keep;
        end else if (advance) begin
            victim_q <= (victim_q == LAST) ? floor_q : victim_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlbl_entries.sv
// Entry storage and the two comparator banks (lookup and fill).
// One entry per generate slot: tag, physical page, valid, preserve flag.
// Assumes fill_idx is chosen by the parent so tags stay unique.
module tlbl_entries #(
    parameter int ENTRIES = tlbl_pkg::DEF_ENTRIES,
    parameter int VPN_W   = tlbl_pkg::DEF_VPN_W,
    parameter int PPN_W   = tlbl_pkg::DEF_PPN_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic [ENTRIES-1:0] lk_match,
    output logic [PPN_W-1:0]   lk_ppn_sel,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  logic               fill_keep,
    output logic [ENTRIES-1:0] fill_match,
    input  logic               flush,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] keep_vec
);
    logic [VPN_W-1:0] tag_q [ENTRIES];
    logic [PPN_W-1:0] ppn_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        // Per-entry state: flush clears unpreserved, fill then overrides.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[i] <= 1'b0;
                keep_vec[i]  <= 1'b0;
                tag_q[i]     <= '0;
                ppn_q[i]     <= '0;
            end else begin
                if (flush && !keep_vec[i]) valid_vec[i] <= 1'b0;
                if (fill_en && fill_idx == IDX_W'(i)) begin
                    valid_vec[i] <= 1'b1;
                    keep_vec[i]  <= fill_keep;
                    tag_q[i]     <= fill_vpn;
                    ppn_q[i]     <= fill_ppn;
                end
            end
        end
        assign lk_match[i]   = valid_vec[i] && (tag_q[i] == lk_vpn);
        assign fill_match[i] = valid_vec[i] && (tag_q[i] == fill_vpn);
    end

    // Lookup data: OR of physical pages of matching entries.
    always_comb begin
        lk_ppn_sel = '0;
        for (int k = 0; k < ENTRIES; k++)
            if (lk_match[k]) lk_ppn_sel = lk_ppn_sel | ppn_q[k];
    end
endmodule

// File: rtl/tlb_lockdown_top.sv
// Top of the fully associative translation buffer with base-bounded
// victim replacement. Picks the fill target (existing matching entry or
// victim slot), qualifies the lookup result, wires the control register.
// Assumes at most one fill per cycle and written indices below ENTRIES.
module tlb_lockdown_top #(
    parameter int ENTRIES = tlbl_pkg::DEF_ENTRIES,
    parameter int VPN_W   = tlbl_pkg::DEF_VPN_W,
    parameter int PPN_W   = tlbl_pkg::DEF_PPN_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             walk_req,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             flush,
    input  logic             cr_wr_en,
    input  logic [IDX_W-1:0] cr_wr_floor,
    input  logic [IDX_W-1:0] cr_wr_victim,
    input  logic             cr_wr_keep,
    output logic [IDX_W-1:0] cr_rd_floor,
    output logic [IDX_W-1:0] cr_rd_victim,
    output logic             cr_rd_keep
);
    logic [ENTRIES-1:0] lk_match, fill_match, valid_vec, keep_vec;
    logic [PPN_W-1:0]   lk_ppn_sel;
    logic [IDX_W-1:0]   dup_idx, fill_idx;
    logic               fill_dup, one_hit;

    // Encode the matching slot of an incoming fill.
    always_comb begin
        dup_idx = '0;
        for (int k = 0; k < ENTRIES; k++)
            if (fill_match[k]) dup_idx = dup_idx | IDX_W'(k);
    end

    assign fill_dup = |fill_match;
    assign fill_idx = fill_dup ? dup_idx : cr_rd_victim;

    // Lookup qualification: exactly one matching valid entry is a hit.
    always_comb begin
        one_hit  = ($countones(lk_match) == 1);
        lk_hit   = lk_valid && one_hit;
        lk_ppn   = lk_hit ? lk_ppn_sel : '0;
        walk_req = lk_valid && !one_hit;
    end

    tlbl_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cr_wr_en),
        .wr_floor  (cr_wr_floor),
        .wr_victim (cr_wr_victim),
        .wr_keep   (cr_wr_keep),
        .advance   (fill_en && !fill_dup),
        .floor_q   (cr_rd_floor),
        .victim_q  (cr_rd_victim),
        .keep_q    (cr_rd_keep)
    );

    tlbl_entries #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_entries (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn     (lk_vpn),
        .lk_match   (lk_match),
        .lk_ppn_sel (lk_ppn_sel),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .fill_vpn   (fill_vpn),
        .fill_ppn   (fill_ppn),
        .fill_keep  (cr_rd_keep),
        .fill_match (fill_match),
        .flush      (flush),
        .valid_vec  (valid_vec),
        .keep_vec   (keep_vec)
    );
endmodule

// File: rtl/tlb_lockdown_chk.sv
// Checker for tlb_lockdown_top, attached by bind below.
// Relates control register, entry state and fill strobes across edges.
module tlb_lockdown_chk #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fill_en,
    input logic             fill_dup,
    input logic             flush,
    input logic [IDX_W-1:0] fill_idx,
    input logic             cr_wr_en,
    input logic [IDX_W-1:0] cr_wr_floor,
    input logic [IDX_W-1:0] cr_wr_victim,
    input logic             cr_wr_keep,
    input logic [IDX_W-1:0] cr_rd_floor,
    input logic [IDX_W-1:0] cr_rd_victim,
    input logic             cr_rd_keep,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] keep_vec
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // R4: pointer step or wrap to floor after a victim fill.
    a_r4_victim_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_dup && !cr_wr_en) |=>
        cr_rd_victim == (($past(cr_rd_victim) == LAST) ? $past(cr_rd_floor)
                                                       : $past(cr_rd_victim) + 1'b1));

    // R6: overwriting an existing tag leaves the pointer alone.
    a_r6_dup_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_dup && !cr_wr_en) |=> $stable(cr_rd_victim));

    // R6 / R2: tags remain unique so at most one entry matches.
    a_r6_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R8: control write takes effect at the next edge.
    a_r8_cr_load: assert property (@(posedge clk) disable iff (!rst_n)
        cr_wr_en |=> (cr_rd_floor == $past(cr_wr_floor)) &&
                     (cr_rd_victim == $past(cr_wr_victim)) &&
                     (cr_rd_keep == $past(cr_wr_keep)));

    // R3 / R10: the filled slot is valid afterwards, flush or not.
    a_r3_fill_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_vec[$past(fill_idx)]);

    // R7: flush keeps exactly the preserved valid entries.
    a_r7_flush_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !fill_en) |=> valid_vec == $past(valid_vec & keep_vec));
endmodule

bind tlb_lockdown_top tlb_lockdown_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_en      (fill_en),
    .fill_dup     (fill_dup),
    .flush        (flush),
    .fill_idx     (fill_idx),
    .cr_wr_en     (cr_wr_en),
    .cr_wr_floor  (cr_wr_floor),
    .cr_wr_victim (cr_wr_victim),
    .cr_wr_keep   (cr_wr_keep),
    .cr_rd_floor  (cr_rd_floor),
    .cr_rd_victim (cr_rd_victim),
    .cr_rd_keep   (cr_rd_keep),
    .lk_match     (lk_match),
    .valid_vec    (valid_vec),
    .keep_vec     (keep_vec)
);

// File: tb/tlb_lockdown_top_tb.sv
// Scoreboard bench: lookup driver pushes expectations, a monitor pops them.
module tlb_lockdown_top_tb;
    localparam int ENTRIES = 8;
    localparam int VPN_W   = 20;
    localparam int PPN_W   = 20;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 1'b0, fill_en = 1'b0, flush = 1'b0, cr_wr_en = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic [IDX_W-1:0] cr_wr_floor = '0, cr_wr_victim = '0;
    logic cr_wr_keep = 1'b0;
    logic lk_hit, walk_req, cr_rd_keep;
    logic [PPN_W-1:0] lk_ppn;
    logic [IDX_W-1:0] cr_rd_floor, cr_rd_victim;

    int total = 0, bad = 0;

    typedef struct {
        logic [VPN_W-1:0] vpn;
        logic             hit;
        logic [PPN_W-1:0] ppn;
        string            req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    tlb_lockdown_top #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_dut (.*);

    // Monitor: compare each lookup result at the falling edge.
    always @(negedge clk) begin
        if (lk_valid && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (lk_hit !== e.hit || walk_req !== !e.hit || (e.hit && lk_ppn !== e.ppn)) begin
                bad++;
                $display("FAIL %s vpn=%h hit=%b walk=%b ppn=%h expected hit=%b ppn=%h",
                         e.req, e.vpn, lk_hit, walk_req, lk_ppn, e.hit, e.ppn);
            end
        end
    end

    task automatic look(input logic [VPN_W-1:0] v, input logic h,
                        input logic [PPN_W-1:0] p, input string req);
        exp_t e;
        @(posedge clk); #1;
        fill_en = 0; cr_wr_en = 0; flush = 0;
        lk_vpn = v; lk_valid = 1;
        e.vpn = v; e.hit = h; e.ppn = p; e.req = req;
        sb.push_back(e);
    endtask

    // One cycle of fill / control write / flush, any combination.
    task automatic op(input logic f, input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                      input logic w, input int fl, input int vi, input logic k,
                      input logic fs);
        @(posedge clk); #1;
        lk_valid = 0;
        fill_en = f; fill_vpn = v; fill_ppn = p;
        cr_wr_en = w; cr_wr_floor = IDX_W'(fl); cr_wr_victim = IDX_W'(vi); cr_wr_keep = k;
        flush = fs;
        @(posedge clk); #1;
        fill_en = 0; cr_wr_en = 0; flush = 0;
    endtask

    task automatic fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p);
        op(1, v, p, 0, 0, 0, 0, 0);
    endtask

    task automatic crw(input int fl, input int vi, input logic k);
        op(0, '0, '0, 1, fl, vi, k, 0);
    endtask

    task automatic rd(input int fl, input int vi, input logic k, input string req);
        @(negedge clk);
        total++;
        if (cr_rd_floor !== IDX_W'(fl) || cr_rd_victim !== IDX_W'(vi) || cr_rd_keep !== k) begin
            bad++;
            $display("FAIL %s ctrl=%0d/%0d/%b expected %0d/%0d/%b", req,
                     cr_rd_floor, cr_rd_victim, cr_rd_keep, fl, vi, k);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        rd(0, 0, 0, "R1");
        look('h100, 0, '0, "R1");
        // Pin two entries: floor=i, victim=i, keep=1, one fill each
        op(0, '0, '0, 0, 0, 0, 0, 1);
        crw(0, 0, 1); fill('h100, 'hA00);
        crw(1, 1, 1); fill('h101, 'hA01);
        crw(2, 2, 0);
        rd(2, 2, 0, "R8");
        look('h100, 1, 'hA00, "R2");
        look('h101, 1, 'hA01, "R3");
        look('h177, 0, '0, "R2");
        // Fill slots 2..7; pointer wraps to the floor
        for (int i = 2; i < 8; i++) fill(VPN_W'('h100 + i), PPN_W'('hA00 + i));
        rd(2, 2, 0, "R4");
        fill('h108, 'hA08);               // evicts 0x102 from slot 2
        rd(2, 3, 0, "R4");
        look('h102, 0, '0, "R9");
        look('h100, 1, 'hA00, "R9");
        look('h101, 1, 'hA01, "R9");
        look('h108, 1, 'hA08, "R3");
        // Duplicate tag overwrites in place
        fill('h103, 'hB03);
        rd(2, 3, 0, "R6");
        look('h103, 1, 'hB03, "R6");
        look('h104, 1, 'hA04, "R6");
        // Flush keeps only preserved entries
        op(0, '0, '0, 0, 0, 0, 0, 1);
        look('h100, 1, 'hA00, "R7");
        look('h101, 1, 'hA01, "R7");
        look('h103, 0, '0, "R7");
        look('h108, 0, '0, "R7");
        // Victim below floor
        crw(4, 1, 0);
        fill('h109, 'hA09);               // lands in slot 1, displacing 0x101
        rd(4, 2, 0, "R5");
        look('h101, 0, '0, "R5");
        look('h109, 1, 'hA09, "R5");
        // Control write in the same cycle as a fill
        op(1, 'h10A, 'hA0A, 1, 6, 6, 1, 0);  // fill uses victim 2, keep 0
        rd(6, 6, 1, "R8");
        look('h10A, 1, 'hA0A, "R8");
        crw(6, 6, 0);
        fill('h10B, 'hA0B);
        fill('h10C, 'hA0C);
        rd(6, 6, 0, "R4");
        op(0, '0, '0, 0, 0, 0, 0, 1);
        look('h10A, 0, '0, "R8");
        // Flush together with a fill
        fill('h10D, 'hA0D);
        op(1, 'h10E, 'hA0E, 0, 0, 0, 0, 1);
        look('h10E, 1, 'hA0E, "R10");
        look('h10D, 0, '0, "R10");
        look('h100, 1, 'hA00, "R10");
        @(posedge clk); #1 lk_valid = 0;
        repeat (2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule